// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block sits between a processor and memory and turns 14-bit byte virtual addresses into 12-bit physical addresses. Pages are 64 bytes, so the six low address bits go through untouched. The eight-bit virtual page number is swapped for a six-bit physical page number. A small set-associative cache of recent translations serves most requests one cycle after they are accepted.

When the cache misses, the block adds the page number to a page-table base address and fetches one 16-bit table entry over a valid/ready read port. It then checks the entry's present and permission flags and either returns the physical address or reports a fault. The fault report carries a code and the faulting page number. Entries that produce a fault are never cached, so a retried access fetches the entry again. Only one request is in flight at a time, and a flush input empties the cache.

Top module: `paged_mmu`

## Requirements
- R1: The physical address is {page frame, va[5:0]}: the six offset bits are copied unchanged, and the frame comes from the table entry or the cached copy.
- R2: When the translation is cached, respValid rises in the cycle after the request was accepted, and no table fetch is made.
- R3: On a cache miss, the block requests the entry at address (ptBase + va[13:6]) modulo 4096. It holds pteReqValid and the address steady until pteReqReady.
- R4: Table entry layout: bit 15 present, bit 14 kernel-only, bit 13 readable, bit 12 writable, bits 5:0 page frame. An entry with bit 15 clear gives fault code 1 and is not cached. A retry after the entry becomes present succeeds, and the access after that is served from the cache.
- R5: Fault code 2 (protection) is raised in three cases: a user-mode access to a kernel-only page, a write to a page without the writable flag, or a read from a page without the readable flag.
- R6: Every response reports va[13:6] on respVpn. A faulting response has respPaddr equal to 0, and the code is never 3.
- R7: The cache has 4 sets of 4 ways, and the set index is va[7:6]. Four pages that share a set all stay cached together.
- R8: A fill goes to the lowest invalid way of its set. When no way is invalid, it goes to the way named by that set's rotating pointer. Every fill into a set moves that set's pointer to the way after the one filled.
- R9: A cached entry that passes the permission check on one access still gets checked on every later access. A user access that hits a kernel-only entry returns code 2 without any fetch.
- R10: reqReady is low from the cycle after acceptance until the response, and always while a table fetch is pending.
- R11: Asserting flush for one cycle invalidates every cached translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| ptBase | input | 12 | Page table base address |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 14 | Virtual byte address |
| reqWrite | input | 1 | 1 for write access, 0 for read |
| reqKernel | input | 1 | 1 when the requester runs in kernel mode |
| respValid | output | 1 | One-cycle response strobe |
| respPaddr | output | 12 | Physical address, 0 on fault |
| respFault | output | 2 | 0 none, 1 not present, 2 protection |
| respVpn | output | 8 | Virtual page number of the answered request |
| pteReqValid | output | 1 | Table entry fetch request |
| pteReqReady | input | 1 | Memory accepts fetch request |
| pteReqAddr | output | 12 | Table entry address |
| pteRespValid | input | 1 | Table entry data valid |
| pteRespData | input | 16 | Table entry |

## Verification
The bench builds the block with its default geometry of 4 sets by 4 ways. With that size, five pages sharing one set are enough to drive the rotating victim pointer through a full lap. The eviction order can then be read from which later accesses trigger a fetch. One run also moves the table base near the top of the 12-bit space, so the entry address wraps around.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int VA_W  = 14;
  localparam int PA_W  = 12;
  localparam int OFF_W = 6;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int PTE_W = 16;

  localparam int PTE_PRESENT = 15;
  localparam int PTE_KONLY   = 14;
  localparam int PTE_RD      = 13;
  localparam int PTE_WR      = 12;

  typedef enum logic [1:0] {
    FAULT_NONE   = 2'd0,
    FAULT_ABSENT = 2'd1,
    FAULT_PROT   = 2'd2
  } fault_e;

  typedef struct packed {
    logic kOnly;
    logic rd;
    logic wr;
  } perm_t;

  typedef struct packed {
    logic latchReq;
    logic respHit;
    logic respWalk;
  } ctrl_t;

  function automatic fault_e checkPerm(perm_t p, logic isWrite, logic isKernel);
    if (p.kOnly && !isKernel) return FAULT_PROT;
    if (isWrite && !p.wr) return FAULT_PROT;
    if (!isWrite && !p.rd) return FAULT_PROT;
    return FAULT_NONE;
  endfunction
endpackage

// File: rtl/mmu_tlb.sv
module mmu_tlb
  import mmu_pkg::*;
#(
  parameter int SETS = 4,
  parameter int WAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lookVpn,
  output logic             hit,
  output logic [PPN_W-1:0] hitPpn,
  output perm_t            hitPerm,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  perm_t            fillPerm
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = VPN_W - SET_W;

  logic [WAYS-1:0]  entValid [SETS];
  logic [TAG_W-1:0] entTag   [SETS][WAYS];
  logic [PPN_W-1:0] entPpn   [SETS][WAYS];
  perm_t            entPerm  [SETS][WAYS];
  logic [WAY_W-1:0] rrPtr    [SETS];

  logic [SET_W-1:0] lookSet, fillSet;
  logic [TAG_W-1:0] lookTag, fillTag;
  logic [WAY_W-1:0] victim;

  assign lookSet = lookVpn[SET_W-1:0];
  assign lookTag = lookVpn[VPN_W-1:SET_W];
  assign fillSet = fillVpn[SET_W-1:0];
  assign fillTag = fillVpn[VPN_W-1:SET_W];

  always_comb begin
    hit     = 1'b0;
    hitPpn  = '0;
    hitPerm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (entValid[lookSet][w] && entTag[lookSet][w] == lookTag) begin
        hit     = 1'b1;
        hitPpn  = entPpn[lookSet][w];
        hitPerm = entPerm[lookSet][w];
      end
    end
  end

  always_comb begin
    victim = rrPtr[fillSet];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!entValid[fillSet][w]) victim = WAY_W'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        entValid[s] <= '0;
        rrPtr[s]    <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) entValid[s] <= '0;
    end else if (fillEn) begin
      entValid[fillSet][victim] <= 1'b1;
      rrPtr[fillSet]            <= victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn && !flush) begin
      entTag[fillSet][victim]  <= fillTag;
      entPpn[fillSet][victim]  <= fillPpn;
      entPerm[fillSet][victim] <= fillPerm;
    end
  end
endmodule

// File: rtl/mmu_datapath.sv
module mmu_datapath
  import mmu_pkg::*;
#(
  parameter int SETS = 4,
  parameter int WAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  ctrl_t            ctrl,
  input  logic [PA_W-1:0]  ptBase,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqKernel,
  input  logic [PTE_W-1:0] pteRespData,
  output logic             hit,
  output logic [PA_W-1:0]  pteReqAddr,
  output logic             respValid,
  output logic [PA_W-1:0]  respPaddr,
  output logic [1:0]       respFault,
  output logic [VPN_W-1:0] respVpn
);
  logic [VA_W-1:0]  curVa;
  logic             curWrite, curKernel;
  logic [VPN_W-1:0] curVpn;
  logic [PPN_W-1:0] hitPpn, pickPpn;
  perm_t            hitPerm, ptePerm;
  fault_e           hitFault, walkFault, pickFault;
  logic             fillEn;

  assign curVpn = curVa[VA_W-1:OFF_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curVa     <= '0;
      curWrite  <= 1'b0;
      curKernel <= 1'b0;
    end else if (ctrl.latchReq) begin
      curVa     <= reqVaddr;
      curWrite  <= reqWrite;
      curKernel <= reqKernel;
    end
  end

  assign pteReqAddr = ptBase + PA_W'(curVpn);

  assign ptePerm = '{kOnly: pteRespData[PTE_KONLY], rd: pteRespData[PTE_RD],
                     wr: pteRespData[PTE_WR]};

  always_comb begin
    hitFault  = checkPerm(hitPerm, curWrite, curKernel);
    walkFault = pteRespData[PTE_PRESENT] ? checkPerm(ptePerm, curWrite, curKernel)
                                         : FAULT_ABSENT;
    if (ctrl.respWalk) begin
      pickFault = walkFault;
      pickPpn   = pteRespData[PPN_W-1:0];
    end else begin
      pickFault = hitFault;
      pickPpn   = hitPpn;
    end
  end

  assign fillEn = ctrl.respWalk && (walkFault == FAULT_NONE);

  mmu_tlb #(.SETS(SETS), .WAYS(WAYS)) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lookVpn  (curVpn),
    .hit      (hit),
    .hitPpn   (hitPpn),
    .hitPerm  (hitPerm),
    .fillEn   (fillEn),
    .fillVpn  (curVpn),
    .fillPpn  (pteRespData[PPN_W-1:0]),
    .fillPerm (ptePerm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid <= 1'b0;
      respPaddr <= '0;
      respFault <= FAULT_NONE;
      respVpn   <= '0;
    end else begin
      respValid <= ctrl.respHit | ctrl.respWalk;
      if (ctrl.respHit | ctrl.respWalk) begin
        respFault <= pickFault;
        respVpn   <= curVpn;
        respPaddr <= (pickFault == FAULT_NONE) ? {pickPpn, curVa[OFF_W-1:0]} : '0;
      end
    end
  end
endmodule

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  reqValid,
  input  logic  hit,
  input  logic  pteReqReady,
  input  logic  pteRespValid,
  output logic  reqReady,
  output logic  pteReqValid,
  output ctrl_t ctrl
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FETCH, ST_WAIT} state_e;
  state_e state, nextState;

  always_comb begin
    nextState     = state;
    ctrl          = '0;
    reqReady      = (state == ST_IDLE);
    pteReqValid   = (state == ST_FETCH);
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctrl.latchReq = 1'b1;
        nextState     = ST_LOOK;
      end
      ST_LOOK: if (hit) begin
        ctrl.respHit = 1'b1;
        nextState    = ST_IDLE;
      end else begin
        nextState = ST_FETCH;
      end
      ST_FETCH: if (pteReqReady) nextState = ST_WAIT;
      ST_WAIT: if (pteRespValid) begin
        ctrl.respWalk = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end
endmodule

// File: rtl/paged_mmu.sv
module paged_mmu
  import mmu_pkg::*;
#(
  parameter int SETS = 4,
  parameter int WAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PA_W-1:0]  ptBase,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  input  logic             reqKernel,
  output logic             respValid,
  output logic [PA_W-1:0]  respPaddr,
  output logic [1:0]       respFault,
  output logic [VPN_W-1:0] respVpn,
  output logic             pteReqValid,
  input  logic             pteReqReady,
  output logic [PA_W-1:0]  pteReqAddr,
  input  logic             pteRespValid,
  input  logic [PTE_W-1:0] pteRespData
);
  ctrl_t ctrl;
  logic  hit;

  mmu_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reqValid     (reqValid),
    .hit          (hit),
    .pteReqReady  (pteReqReady),
    .pteRespValid (pteRespValid),
    .reqReady     (reqReady),
    .pteReqValid  (pteReqValid),
    .ctrl         (ctrl)
  );

  mmu_datapath #(.SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .ctrl        (ctrl),
    .ptBase      (ptBase),
    .reqVaddr    (reqVaddr),
    .reqWrite    (reqWrite),
    .reqKernel   (reqKernel),
    .pteRespData (pteRespData),
    .hit         (hit),
    .pteReqAddr  (pteReqAddr),
    .respValid   (respValid),
    .respPaddr   (respPaddr),
    .respFault   (respFault),
    .respVpn     (respVpn)
  );
endmodule

// File: rtl/mmu_checker.sv
module mmu_checker
  import mmu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reqValid,
  input logic             reqReady,
  input logic [VA_W-1:0]  reqVaddr,
  input logic             respValid,
  input logic [PA_W-1:0]  respPaddr,
  input logic [1:0]       respFault,
  input logic [VPN_W-1:0] respVpn,
  input logic             pteReqValid,
  input logic             pteReqReady,
  input logic [PA_W-1:0]  pteReqAddr
);
  logic [VA_W-1:0] seenVa;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seenVa <= '0;
    else if (reqValid && reqReady) seenVa <= reqVaddr;
  end

  assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pteReqValid && !pteReqReady |=> pteReqValid && $stable(pteReqAddr));

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    respValid && respFault == 2'd0 |-> respPaddr[OFF_W-1:0] == seenVa[OFF_W-1:0]);

  assert_fault_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    respValid && respFault != 2'd0 |-> respPaddr == '0);

  assert_fault_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> respFault != 2'd3);

  assert_vpn_report_R6: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> respVpn == seenVa[VA_W-1:OFF_W]);

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);

  assert_busy_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pteReqValid |-> !reqReady);
endmodule

bind paged_mmu mmu_checker u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqVaddr    (reqVaddr),
  .respValid   (respValid),
  .respPaddr   (respPaddr),
  .respFault   (respFault),
  .respVpn     (respVpn),
  .pteReqValid (pteReqValid),
  .pteReqReady (pteReqReady),
  .pteReqAddr  (pteReqAddr)
);

// File: tb/paged_mmu_tb.sv
module paged_mmu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [11:0] ptBase = 12'h100;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [13:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqKernel = 1'b0;
  logic        respValid;
  logic [11:0] respPaddr;
  logic [1:0]  respFault;
  logic [7:0]  respVpn;
  logic        pteReqValid;
  logic        pteReqReady = 1'b0;
  logic [11:0] pteReqAddr;
  logic        pteRespValid = 1'b0;
  logic [15:0] pteRespData = '0;

  always #10 clk = ~clk;

  paged_mmu u_dut (.*);

  typedef struct {
    logic [11:0] pa;
    logic [1:0]  f;
    logic [7:0]  vpn;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [15:0] ptMem[int];
  int          checks = 0;
  int          fails = 0;
  int          fetches = 0;
  logic [11:0] lastAddr = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkPte(bit p, bit k, bit r, bit w, logic [5:0] ppn);
    return {p, k, r, w, 6'b0, ppn};
  endfunction

  task automatic setPte(input logic [7:0] vpn, input logic [15:0] e);
    ptMem[int'((ptBase + 12'(vpn)) & 12'hFFF)] = e;
  endtask

  // memory model for table fetches
  initial forever begin
    @(negedge clk);
    if (pteReqValid) begin
      lastAddr = pteReqAddr;
      fetches++;
      pteReqReady = 1'b1;
      @(negedge clk);
      pteReqReady  = 1'b0;
      pteRespValid = 1'b1;
      pteRespData  = ptMem.exists(int'(lastAddr)) ? ptMem[int'(lastAddr)] : 16'h0;
      @(negedge clk);
      pteRespValid = 1'b0;
    end
  end

  // monitor: pop and compare
  initial forever begin
    @(negedge clk);
    if (respValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(respPaddr == e.pa, e.tag, "paddr", int'(respPaddr), int'(e.pa));
        chk(respFault == e.f, e.tag, "fault", int'(respFault), int'(e.f));
        chk(respVpn == e.vpn, "R6", "vpn", int'(respVpn), int'(e.vpn));
      end
    end
  end

  task automatic access(input logic [7:0] vpn, input logic [5:0] off, input bit wr,
                        input bit kern, input logic [1:0] f, input logic [5:0] ppn,
                        input int expFetch, input string tag);
    exp_t e;
    int   f0;
    int   lat;
    e.pa  = (f == 2'd0) ? {ppn, off} : 12'h0;
    e.f   = f;
    e.vpn = vpn;
    e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    f0 = fetches;
    reqValid  = 1'b1;
    reqVaddr  = {vpn, off};
    reqWrite  = wr;
    reqKernel = kern;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R10", "ready while busy", int'(reqReady), 0);
    lat = 0;
    while (!respValid) begin
      @(negedge clk);
      lat++;
    end
    chk(fetches - f0 == expFetch, tag, "fetch count", fetches - f0, expFetch);
    if (expFetch == 0) chk(lat == 1, "R2", "hit latency", lat, 1);
  endtask

  task automatic pulseFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    setPte(8'h05, mkPte(1, 0, 1, 1, 6'h2A));
    setPte(8'h07, mkPte(0, 0, 1, 1, 6'h11));
    setPte(8'h09, mkPte(1, 1, 1, 1, 6'h33));
    setPte(8'h0D, mkPte(1, 0, 1, 0, 6'h0D));
    setPte(8'h11, mkPte(1, 0, 0, 1, 6'h21));
    setPte(8'h02, mkPte(1, 0, 1, 1, 6'h01));
    setPte(8'h06, mkPte(1, 0, 1, 1, 6'h02));
    setPte(8'h0A, mkPte(1, 0, 1, 1, 6'h03));
    setPte(8'h0E, mkPte(1, 0, 1, 1, 6'h04));
    setPte(8'h12, mkPte(1, 0, 1, 1, 6'h05));

    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R10", "reset ready", int'(reqReady), 1);
    chk(respValid == 1'b0, "R6", "reset respValid", int'(respValid), 0);
    chk(pteReqValid == 1'b0, "R3", "reset fetch", int'(pteReqValid), 0);
    rst_n = 1'b1;

    // R1 R3: miss then hit, offsets at both ends
    access(8'h05, 6'h13, 0, 0, 2'd0, 6'h2A, 1, "R1");
    chk(lastAddr == 12'h105, "R3", "fetch addr", int'(lastAddr), 'h105);
    access(8'h05, 6'h3F, 1, 0, 2'd0, 6'h2A, 0, "R2");
    access(8'h05, 6'h00, 0, 0, 2'd0, 6'h2A, 0, "R1");

    // R4: not present, not cached, retry succeeds then hits
    access(8'h07, 6'h04, 0, 0, 2'd1, 6'h00, 1, "R4");
    access(8'h07, 6'h04, 0, 0, 2'd1, 6'h00, 1, "R4");
    setPte(8'h07, mkPte(1, 0, 1, 1, 6'h11));
    access(8'h07, 6'h04, 0, 0, 2'd0, 6'h11, 1, "R4");
    access(8'h07, 6'h08, 0, 0, 2'd0, 6'h11, 0, "R4");

    // R5 R9: kernel-only page
    access(8'h09, 6'h01, 0, 0, 2'd2, 6'h00, 1, "R5");
    access(8'h09, 6'h01, 0, 1, 2'd0, 6'h33, 1, "R5");
    access(8'h09, 6'h02, 0, 0, 2'd2, 6'h00, 0, "R9");
    access(8'h09, 6'h02, 1, 1, 2'd0, 6'h33, 0, "R9");

    // R5: read-only and write-only pages
    access(8'h0D, 6'h05, 0, 0, 2'd0, 6'h0D, 1, "R5");
    access(8'h0D, 6'h05, 1, 0, 2'd2, 6'h00, 0, "R9");
    access(8'h11, 6'h06, 0, 0, 2'd2, 6'h00, 1, "R5");
    access(8'h11, 6'h06, 1, 0, 2'd0, 6'h21, 1, "R5");

    // R7 R8: set 2 fill and rotation
    access(8'h02, 6'h00, 0, 0, 2'd0, 6'h01, 1, "R7");
    access(8'h06, 6'h00, 0, 0, 2'd0, 6'h02, 1, "R7");
    access(8'h0A, 6'h00, 0, 0, 2'd0, 6'h03, 1, "R7");
    access(8'h0E, 6'h00, 0, 0, 2'd0, 6'h04, 1, "R7");
    access(8'h02, 6'h01, 0, 0, 2'd0, 6'h01, 0, "R7");
    access(8'h06, 6'h01, 0, 0, 2'd0, 6'h02, 0, "R7");
    access(8'h0A, 6'h01, 0, 0, 2'd0, 6'h03, 0, "R7");
    access(8'h0E, 6'h01, 0, 0, 2'd0, 6'h04, 0, "R7");
    access(8'h12, 6'h00, 0, 0, 2'd0, 6'h05, 1, "R8");
    access(8'h0A, 6'h02, 0, 0, 2'd0, 6'h03, 0, "R8");
    access(8'h02, 6'h02, 0, 0, 2'd0, 6'h01, 1, "R8");
    access(8'h0E, 6'h02, 0, 0, 2'd0, 6'h04, 0, "R8");
    access(8'h06, 6'h02, 0, 0, 2'd0, 6'h02, 1, "R8");
    access(8'h12, 6'h02, 0, 0, 2'd0, 6'h05, 0, "R8");

    // R11: flush
    access(8'h05, 6'h07, 0, 0, 2'd0, 6'h2A, 0, "R11");
    pulseFlush();
    access(8'h05, 6'h07, 0, 0, 2'd0, 6'h2A, 1, "R11");

    // R3: base near the top wraps
    ptBase = 12'hFF0;
    setPte(8'h20, mkPte(1, 0, 1, 1, 6'h3C));
    access(8'h20, 6'h2B, 0, 0, 2'd0, 6'h3C, 1, "R3");
    chk(lastAddr == 12'h010, "R3", "wrap addr", int'(lastAddr), 'h010);

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R6", "pending expectations", expQ.size(), 0);
    finishRun();
  end
endmodule